// File: doc/BRIEF.md
# Function Event Notification Queue

This block buffers asynchronous event records raised for I/O functions and hands them to a software-facing consumer one at a time, oldest first. Error records are pushed directly by a producer port. Availability records are generated by a built-in attach/detach sequencer. This sequencer converts a single plug or unplug command into a fixed, ordered chain of state-transition records. Both kinds of record share one first-in first-out store.

Each stored record raises a one-cycle notification pulse. A level output shows whether any record is waiting. The consumer issues a pop request and receives a formatted response one cycle later. When the queue is empty, the response carries a failure status and no payload.

Top module: `fn_event_queue`

## Requirements
- R1: A cycle with `err_push` high stores an error record (content code 1) holding `err_fid`, `err_fh`, `err_pec`, `err_faddr` and `err_qual`, and a later pop returns exactly those values with `resp_cc` = 1.
- R2: Records emitted by the sequencer are availability records (content code 2) carrying the function's current ID and handle; their `resp_faddr` and `resp_qual` read back as zero. Only codes 1 and 2 ever appear in a successful response.
- R3: Records leave in the order they were stored.
- R4: A pop request produces `resp_valid` for exactly one cycle, on the cycle after the request. For a non-empty queue this response has `resp_status` = 0, `resp_nt` = 2 and `resp_len` = RESP_LEN (default 64), and the head record is removed. For an empty queue it has `resp_status` = 1, and `resp_cc`, `resp_nt`, `resp_len` and all data fields are 0.
- R5: `have_event` is high exactly when at least one record is held. It updates on the cycle after the push or pop that changes the count.
- R6: `notify` is high for one cycle after each cycle in which a record is stored, and is low otherwise.
- R7: The queue holds DEPTH records (default 16). A pop in the same cycle is taken first. A push that still finds the queue full is dropped and sets `overflow`, which stays high until reset. A push with a same-cycle pop on a full queue is stored.
- R8: A plug command loads `plug_fid`/`plug_fh` into `fn_fid`/`fn_fh` and sets `fn_configured`. It then emits, on the next free cycles, event code 0x0301 (reserved to standby) followed by 0x0302 (standby to configured).
- R9: An unplug command first emits 0x0303 (configured to standby) and clears `fn_configured`, but only if the function was configured. It always emits 0x0304 (standby to reserved), and `fn_fid` and `fn_fh` become zero in the cycle that record is stored.
- R10: When `err_push` falls in a cycle where the sequencer has a record to emit, the error record is stored and the sequencer step waits one cycle; no record is lost.
- R11: Plug, unplug and deconfigure commands are ignored while `seq_busy` is high. In idle, plug wins over unplug, and unplug wins over deconfigure. A deconfigure clears `fn_configured`.
- R12: After reset, `have_event`, `notify`, `overflow`, `resp_valid`, `seq_busy`, `fn_configured`, `fn_fid` and `fn_fh` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_push | input | 1 | Store an error record this cycle |
| err_fid | input | 32 | Error record function ID |
| err_fh | input | 32 | Error record function handle |
| err_pec | input | 16 | Error record event code |
| err_faddr | input | 64 | Error record fault address |
| err_qual | input | 32 | Error record qualifier word |
| plug_req | input | 1 | Attach command |
| unplug_req | input | 1 | Detach command |
| deconfig_req | input | 1 | Mark the function not configured |
| plug_fid | input | 32 | Function ID loaded on attach |
| plug_fh | input | 32 | Function handle loaded on attach |
| pop_req | input | 1 | Remove the head record into the response |
| have_event | output | 1 | At least one record waiting |
| notify | output | 1 | One-cycle pulse per stored record |
| overflow | output | 1 | Sticky: a record was dropped |
| resp_valid | output | 1 | Response fields valid this cycle |
| resp_status | output | 1 | 0 = record returned, 1 = queue was empty |
| resp_cc | output | 2 | Content code of returned record |
| resp_nt | output | 8 | Notification type (2 on success) |
| resp_len | output | 16 | Response length (RESP_LEN on success) |
| resp_fid | output | 32 | Returned function ID |
| resp_fh | output | 32 | Returned function handle |
| resp_pec | output | 16 | Returned event code |
| resp_faddr | output | 64 | Returned fault address |
| resp_qual | output | 32 | Returned qualifier word |
| fn_fid | output | 32 | Current function ID held by the sequencer |
| fn_fh | output | 32 | Current function handle held by the sequencer |
| fn_configured | output | 1 | Function currently configured |
| seq_busy | output | 1 | Sequencer has records left to emit |

## Verification
The error push port and the sequencer compete for the single store port. The bench provokes this by asserting `err_push` in the cycle just after a plug command has been accepted. It judges the outcome from the popped order: error first, then 0x0301 and 0x0302. A second collision is a push and a pop in the same cycle, tried both on an empty queue (the pop fails, the push is kept) and on a full one (both succeed, no overflow). A behavioural queue model runs alongside the design and is compared against every output on every clock.

// File: rtl/fevq_pkg.sv
// Shared types and constants for the function event queue.
// Assumes: record fields sized for 32-bit IDs/handles and 64-bit addresses.
package fevq_pkg;
    localparam int FID_W  = 32;
    localparam int FH_W   = 32;
    localparam int PEC_W  = 16;
    localparam int ADDR_W = 64;
    localparam int QUAL_W = 32;
    localparam int CC_W   = 2;
    localparam int NT_W   = 8;
    localparam int LEN_W  = 16;

    localparam logic [CC_W-1:0] CC_ERROR = 2'd1;
    localparam logic [CC_W-1:0] CC_AVAIL = 2'd2;
    localparam logic [NT_W-1:0] NT_CODE  = 8'd2;

    localparam logic [PEC_W-1:0] PEC_RSV_TO_STBY = 16'h0301;
    localparam logic [PEC_W-1:0] PEC_STBY_TO_CFG = 16'h0302;
    localparam logic [PEC_W-1:0] PEC_CFG_TO_STBY = 16'h0303;
    localparam logic [PEC_W-1:0] PEC_STBY_TO_RSV = 16'h0304;

    typedef struct packed {
        logic [CC_W-1:0]   cc;
        logic [FID_W-1:0]  fid;
        logic [FH_W-1:0]   fh;
        logic [PEC_W-1:0]  pec;
        logic [ADDR_W-1:0] faddr;
        logic [QUAL_W-1:0] qual;
    } fevq_rec_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_ATTACH_A, SQ_ATTACH_B, SQ_DETACH_A, SQ_DETACH_B
    } fevq_seq_e;
endpackage

// File: rtl/fevq_store.sv
// Circular record store with a pop-before-push rule.
// Assumes: at most one push and one pop per cycle; the memory itself is not reset.
module fevq_store
    import fevq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  fevq_rec_t push_rec,
    input  logic      pop,
    output fevq_rec_t head_rec,
    output logic      empty,
    output logic      pop_ok,
    output logic      push_ok,
    output logic      dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    fevq_rec_t mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    // Accept/reject decisions; a same-cycle pop makes room first.
    always_comb begin
        empty    = (cnt == '0);
        pop_ok   = pop && !empty;
        push_ok  = push && ((cnt != FULLC) || pop_ok);
        dropped  = push && !push_ok;
        head_rec = mem[rd_ptr];
    end

    // Record storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_rec;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/fevq_hp_seq.sv
// Attach/detach sequencer: turns plug/unplug commands into ordered
// availability records and tracks the function's ID, handle and state.
// Assumes: hold is high when another producer owns the store port.
module fevq_hp_seq
    import fevq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             plug_req,
    input  logic             unplug_req,
    input  logic             deconfig_req,
    input  logic [FID_W-1:0] plug_fid,
    input  logic [FH_W-1:0]  plug_fh,
    input  logic             hold,
    output logic             emit,
    output fevq_rec_t        emit_rec,
    output logic [FID_W-1:0] fn_fid,
    output logic [FH_W-1:0]  fn_fh,
    output logic             fn_configured,
    output logic             busy
);
    fevq_seq_e state;
    logic [PEC_W-1:0] pec_sel;

    // Event code for the current step of the chain.
    always_comb begin
        unique case (state)
            SQ_ATTACH_A: pec_sel = PEC_RSV_TO_STBY;
            SQ_ATTACH_B: pec_sel = PEC_STBY_TO_CFG;
            SQ_DETACH_A: pec_sel = PEC_CFG_TO_STBY;
            SQ_DETACH_B: pec_sel = PEC_STBY_TO_RSV;
            default:     pec_sel = '0;
        endcase
        busy     = (state != SQ_IDLE);
        emit     = busy && !hold;
        emit_rec = '{cc: CC_AVAIL, fid: fn_fid, fh: fn_fh, pec: pec_sel,
                     faddr: '0, qual: '0};
    end

    // Command acceptance in idle and chain advance when the port is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= SQ_IDLE;
            fn_fid        <= '0;
            fn_fh         <= '0;
            fn_configured <= 1'b0;
        end else if (state == SQ_IDLE) begin
            if (plug_req) begin
                fn_fid        <= plug_fid;
                fn_fh         <= plug_fh;
                fn_configured <= 1'b1;
                state         <= SQ_ATTACH_A;
            end else if (unplug_req) begin
                state <= fn_configured ? SQ_DETACH_A : SQ_DETACH_B;
            end else if (deconfig_req) begin
                fn_configured <= 1'b0;
            end
        end else if (emit) begin
            unique case (state)
                SQ_ATTACH_A: state <= SQ_ATTACH_B;
                SQ_ATTACH_B: state <= SQ_IDLE;
                SQ_DETACH_A: begin
                    fn_configured <= 1'b0;
                    state         <= SQ_DETACH_B;
                end
                SQ_DETACH_B: begin
                    fn_fid <= '0;
                    fn_fh  <= '0;
                    state  <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fevq_resp.sv
// Pop response formatter: registers the head record with fixed header
// fields, or a failure status with empty payload when nothing was held.
// Assumes: head is valid whenever pop_ok is high.
module fevq_resp
    import fevq_pkg::*;
#(
    parameter int RESP_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             pop_ok,
    input  fevq_rec_t        head,
    output logic             resp_valid,
    output logic             resp_status,
    output logic [NT_W-1:0]  resp_nt,
    output logic [LEN_W-1:0] resp_len,
    output fevq_rec_t        resp_rec
);
    localparam logic [LEN_W-1:0] LEN_C = LEN_W'(RESP_LEN);

    // Capture one response per pop request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= 1'b0;
            resp_nt     <= '0;
            resp_len    <= '0;
            resp_rec    <= '0;
        end else begin
            resp_valid <= pop;
            if (pop) begin
                resp_status <= !pop_ok;
                resp_nt     <= pop_ok ? NT_CODE : '0;
                resp_len    <= pop_ok ? LEN_C : '0;
                resp_rec    <= pop_ok ? head : '0;
            end
        end
    end
endmodule

// File: rtl/fn_event_queue.sv
// Function event notification queue top: arbitrates error pushes against
// the attach/detach sequencer, stores records FIFO, raises a notify pulse
// per stored record, keeps a sticky overflow flag and formats pops.
// Assumes: error pushes take priority; the sequencer waits on a clash.
module fn_event_queue
    import fevq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int RESP_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_push,
    input  logic [FID_W-1:0]  err_fid,
    input  logic [FH_W-1:0]   err_fh,
    input  logic [PEC_W-1:0]  err_pec,
    input  logic [ADDR_W-1:0] err_faddr,
    input  logic [QUAL_W-1:0] err_qual,
    input  logic              plug_req,
    input  logic              unplug_req,
    input  logic              deconfig_req,
    input  logic [FID_W-1:0]  plug_fid,
    input  logic [FH_W-1:0]   plug_fh,
    input  logic              pop_req,
    output logic              have_event,
    output logic              notify,
    output logic              overflow,
    output logic              resp_valid,
    output logic              resp_status,
    output logic [CC_W-1:0]   resp_cc,
    output logic [NT_W-1:0]   resp_nt,
    output logic [LEN_W-1:0]  resp_len,
    output logic [FID_W-1:0]  resp_fid,
    output logic [FH_W-1:0]   resp_fh,
    output logic [PEC_W-1:0]  resp_pec,
    output logic [ADDR_W-1:0] resp_faddr,
    output logic [QUAL_W-1:0] resp_qual,
    output logic [FID_W-1:0]  fn_fid,
    output logic [FH_W-1:0]   fn_fh,
    output logic              fn_configured,
    output logic              seq_busy
);
    fevq_rec_t err_rec, seq_rec, push_rec, head_rec, resp_rec;
    logic seq_emit, push, empty, pop_ok, push_ok, dropped;

    fevq_hp_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .plug_req(plug_req), .unplug_req(unplug_req),
        .deconfig_req(deconfig_req),
        .plug_fid(plug_fid), .plug_fh(plug_fh),
        .hold(err_push),
        .emit(seq_emit), .emit_rec(seq_rec),
        .fn_fid(fn_fid), .fn_fh(fn_fh),
        .fn_configured(fn_configured), .busy(seq_busy)
    );

    // Store-port arbitration: the error producer wins.
    always_comb begin
        err_rec  = '{cc: CC_ERROR, fid: err_fid, fh: err_fh, pec: err_pec,
                     faddr: err_faddr, qual: err_qual};
        push     = err_push || seq_emit;
        push_rec = err_push ? err_rec : seq_rec;
    end

    fevq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_rec(push_rec), .pop(pop_req),
        .head_rec(head_rec), .empty(empty),
        .pop_ok(pop_ok), .push_ok(push_ok), .dropped(dropped)
    );

    fevq_resp #(.RESP_LEN(RESP_LEN)) u_resp (
        .clk(clk), .rst_n(rst_n),
        .pop(pop_req), .pop_ok(pop_ok), .head(head_rec),
        .resp_valid(resp_valid), .resp_status(resp_status),
        .resp_nt(resp_nt), .resp_len(resp_len), .resp_rec(resp_rec)
    );

    // Notify pulse per stored record and sticky overflow on a drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify   <= 1'b0;
            overflow <= 1'b0;
        end else begin
            notify   <= push_ok;
            overflow <= overflow || dropped;
        end
    end

    // Output unpacking.
    always_comb begin
        have_event = !empty;
        resp_cc    = resp_rec.cc;
        resp_fid   = resp_rec.fid;
        resp_fh    = resp_rec.fh;
        resp_pec   = resp_rec.pec;
        resp_faddr = resp_rec.faddr;
        resp_qual  = resp_rec.qual;
    end
endmodule

// File: rtl/fevq_checker.sv
// Property checker for fn_event_queue, attached by bind.
// Assumes: observes top-level ports only.
module fevq_checker
    import fevq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              err_push,
    input logic              pop_req,
    input logic              have_event,
    input logic              notify,
    input logic              overflow,
    input logic              resp_valid,
    input logic              resp_status,
    input logic [CC_W-1:0]   resp_cc,
    input logic [NT_W-1:0]   resp_nt,
    input logic [LEN_W-1:0]  resp_len,
    input logic [ADDR_W-1:0] resp_faddr,
    input logic [QUAL_W-1:0] resp_qual,
    input logic              seq_busy
);
    AST_NOTIFY_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> have_event); // R5
    AST_NOTIFY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> $past(err_push || seq_busy)); // R6
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R7
    AST_NO_POP_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> !resp_valid); // R4
    AST_EMPTY_POP_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !have_event) |=> (resp_valid && resp_status)); // R4
    AST_FAIL_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status) |-> (resp_nt == '0 && resp_len == '0 && resp_cc == '0)); // R4
    AST_LEGAL_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_status) |-> ((resp_cc == CC_ERROR || resp_cc == CC_AVAIL) && resp_nt == NT_CODE)); // R2
    AST_AVAIL_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_status && resp_cc == CC_AVAIL) |-> (resp_faddr == '0 && resp_qual == '0)); // R2
endmodule

bind fn_event_queue fevq_checker u_fevq_checker (.*);

// File: tb/fn_event_queue_test.sv
module fn_event_queue_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_push = 0, plug_req = 0, unplug_req = 0, deconfig_req = 0, pop_req = 0;
    logic [31:0] err_fid = 0, err_fh = 0, err_qual = 0, plug_fid = 0, plug_fh = 0;
    logic [15:0] err_pec = 0;
    logic [63:0] err_faddr = 0;
    logic have_event, notify, overflow, resp_valid, resp_status, fn_configured, seq_busy;
    logic [1:0] resp_cc;
    logic [7:0] resp_nt;
    logic [15:0] resp_len, resp_pec;
    logic [31:0] resp_fid, resp_fh, resp_qual, fn_fid, fn_fh;
    logic [63:0] resp_faddr;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fn_event_queue uut (.*);

    typedef struct {
        int cc; logic [31:0] fid; logic [31:0] fh; logic [15:0] pec;
        logic [63:0] fa; logic [31:0] q;
    } mrec_t;
    mrec_t mq[$];
    mrec_t m_resp;
    bit m_ovf, m_notify, m_rv, m_rs, m_cfg;
    int m_state;
    logic [31:0] m_fid, m_fh;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] step_pec(int st);
        case (st)
            1: return 16'h0301;
            2: return 16'h0302;
            3: return 16'h0303;
            default: return 16'h0304;
        endcase
    endfunction

    task automatic model_step();
        mrec_t pr;
        bit do_push = 0;
        if (!rst_n) begin
            mq.delete(); m_ovf = 0; m_notify = 0; m_rv = 0; m_rs = 0;
            m_cfg = 0; m_state = 0; m_fid = 0; m_fh = 0;
            m_resp = '{0, 0, 0, 0, 0, 0};
            return;
        end
        m_rv = pop_req;
        if (pop_req) begin
            if (mq.size() > 0) begin m_rs = 0; m_resp = mq.pop_front(); end
            else begin m_rs = 1; m_resp = '{0, 0, 0, 0, 0, 0}; end
        end
        if (err_push) begin
            pr = '{1, err_fid, err_fh, err_pec, err_faddr, err_qual};
            do_push = 1;
        end
        if (m_state == 0) begin
            if (plug_req) begin m_fid = plug_fid; m_fh = plug_fh; m_cfg = 1; m_state = 1; end
            else if (unplug_req) m_state = m_cfg ? 3 : 4;
            else if (deconfig_req) m_cfg = 0;
        end else if (!err_push) begin
            pr = '{2, m_fid, m_fh, step_pec(m_state), 0, 0};
            do_push = 1;
            case (m_state)
                1: m_state = 2;
                2: m_state = 0;
                3: begin m_cfg = 0; m_state = 4; end
                default: begin m_fid = 0; m_fh = 0; m_state = 0; end
            endcase
        end
        m_notify = 0;
        if (do_push) begin
            if (mq.size() < 16) begin mq.push_back(pr); m_notify = 1; end
            else m_ovf = 1;
        end
    endtask

    task automatic compare();
        chk("R5 have_event", have_event, mq.size() > 0);
        chk("R6 notify", notify, m_notify);
        chk("R7 overflow", overflow, m_ovf);
        chk("R4 resp_valid", resp_valid, m_rv);
        if (m_rv) begin
            chk("R4 resp_status", resp_status, m_rs);
            chk("R3 resp_cc", resp_cc, m_resp.cc);
            chk("R3 resp_fid", resp_fid, m_resp.fid);
            chk("R3 resp_fh", resp_fh, m_resp.fh);
            chk("R3 resp_pec", resp_pec, m_resp.pec);
            chk("R1 resp_faddr", resp_faddr, m_resp.fa);
            chk("R1 resp_qual", resp_qual, m_resp.q);
            chk("R4 resp_nt", resp_nt, m_rs ? 0 : 2);
            chk("R4 resp_len", resp_len, m_rs ? 0 : 64);
        end
        chk("R8 fn_fid", fn_fid, m_fid);
        chk("R9 fn_fh", fn_fh, m_fh);
        chk("R11 fn_configured", fn_configured, m_cfg);
        chk("R11 seq_busy", seq_busy, m_state != 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        err_push = 0; plug_req = 0; unplug_req = 0; deconfig_req = 0; pop_req = 0;
    endtask

    task automatic push_err(logic [31:0] fid, logic [15:0] pec);
        err_push = 1; err_fid = fid; err_fh = fid ^ 32'h8000_0000; err_pec = pec;
        err_faddr = {fid, ~fid}; err_qual = fid + 7;
    endtask

    task automatic pop_expect(string req, int cc, logic [15:0] pec);
        pop_req = 1;
        tick();
        chk(req, resp_status, 0);
        chk(req, resp_cc, cc);
        chk(req, resp_pec, pec);
    endtask

    initial begin
        tick(); tick();
        // R12: reset state
        chk("R12 have_event", have_event, 0);
        chk("R12 overflow", overflow, 0);
        chk("R12 fn_fid", fn_fid, 0);
        chk("R12 busy", seq_busy, 0);
        rst_n = 1;
        tick();
        // R4: empty pop
        pop_req = 1; tick();
        chk("R4 empty status", resp_status, 1);
        chk("R4 empty fid", resp_fid, 0);
        // R1/R3: three error records, FIFO order
        for (int i = 0; i < 3; i++) begin push_err(32'h10 + i, 16'h0040 + 16'(i)); tick(); end
        chk("R6 notify after push", notify, 1);
        pop_expect("R3 first out", 1, 16'h0040);
        chk("R1 faddr", resp_faddr, {32'h10, ~32'h10});
        chk("R1 qual", resp_qual, 32'h17);
        pop_expect("R3 second out", 1, 16'h0041);
        pop_expect("R3 third out", 1, 16'h0042);
        // R8: attach chain
        plug_req = 1; plug_fid = 32'h2A; plug_fh = 32'h8000_002A; tick();
        chk("R8 fid loaded", fn_fid, 32'h2A);
        // R11: plug while busy is ignored
        plug_req = 1; plug_fid = 32'h99; tick();
        tick();
        chk("R11 fid kept", fn_fid, 32'h2A);
        pop_expect("R8 first", 2, 16'h0301);
        chk("R2 avail faddr", resp_faddr, 0);
        pop_expect("R8 second", 2, 16'h0302);
        // R9: unplug while configured
        unplug_req = 1; tick(); tick(); tick();
        chk("R9 fid cleared", fn_fid, 0);
        chk("R9 fh cleared", fn_fh, 0);
        pop_expect("R9 cfg to stby", 2, 16'h0303);
        pop_expect("R9 stby to rsv", 2, 16'h0304);
        // R9/R11: deconfigured function emits only one record on unplug
        plug_req = 1; plug_fid = 32'h5; plug_fh = 32'h5; tick(); tick(); tick();
        pop_req = 1; tick(); pop_req = 1; tick();
        deconfig_req = 1; tick();
        chk("R11 deconfig", fn_configured, 0);
        unplug_req = 1; tick(); tick();
        pop_expect("R9 single record", 2, 16'h0304);
        chk("R5 drained", have_event, 0);
        // R10: error push collides with sequencer step
        plug_req = 1; plug_fid = 32'h7; plug_fh = 32'h7; tick();
        push_err(32'h77, 16'h00EE); tick();
        tick(); tick();
        pop_expect("R10 error first", 1, 16'h00EE);
        pop_expect("R10 then 0301", 2, 16'h0301);
        pop_expect("R10 then 0302", 2, 16'h0302);
        // R7: push+pop on empty, then fill
        push_err(32'h30, 16'h0001); pop_req = 1; tick();
        chk("R7 empty push+pop status", resp_status, 1);
        chk("R7 push kept", have_event, 1);
        for (int i = 1; i < 16; i++) begin push_err(32'h30 + i, 16'(i + 1)); tick(); end
        push_err(32'h50, 16'h0050); pop_req = 1; tick();
        chk("R7 full push+pop no overflow", overflow, 0);
        push_err(32'h51, 16'h0051); tick();
        chk("R7 overflow set", overflow, 1);
        chk("R6 no notify on drop", notify, 0);
        for (int i = 0; i < 16; i++) begin pop_req = 1; tick(); end
        chk("R3 last kept", resp_pec, 16'h0050);
        chk("R7 overflow sticky", overflow, 1);
        pop_req = 1; tick();
        chk("R4 empty again", resp_status, 1);
        tick();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule